// File: doc/BRIEF.md
# Synonym Detector for a Virtually Indexed, Physically Tagged Cache

This unit sits beside a two-way, virtually indexed and physically tagged first-level cache. It keeps its own duplicate copy of that cache's physical tags and valid bits. The primary cache uses 64-byte blocks and a 9-bit set index, and pages are at least 4 KB. Because of this, the top 3 index bits come from the virtual address. One physical block can therefore sit in any of 8 candidate sets, in either way, which gives 16 possible locations.

When the primary cache misses, the requester presents the missing physical block address and the 3 virtual index bits that it used. This happens at the same time as the second-level lookup. In the same cycle, the unit compares the tag against all 16 locations. If the block already lives at a different virtual index, the unit reports a synonym together with its set and way.

That set and way is also the invalidate command for the primary tag array. On the following clock edge, the unit clears the same entry in its duplicate copy. Whenever the primary cache fills a line, a fill port writes the same tag into the duplicate copy, so the two copies stay identical.

Top module: `syn_detect`

## Requirements
- R1: Reset clears every valid bit of the duplicate tag copy, so a lookup after reset reports no synonym.
- R2: A fill writes its tag into the addressed set and way and marks the entry valid. A later lookup for that block finds it.
- R3: A lookup presents a 34-bit block address: bits [33:6] are the 28-bit tag and bits [5:0] are the low set-index bits. It searches sets {c, low6} for all 8 values of c, in both ways, and does so in the same cycle. On a match, `syn_hit` is high, `syn_set` = {c, low6} (c in bits [8:6]) and `syn_way` names the way.
- R4: A match in the set {req_vhi, low6}, which is the requester's own set, is never reported.
- R5: An entry whose tag differs, or which is invalid, does not match.
- R6: The entry reported by a hit becomes invalid at the next clock edge, so the same lookup repeated afterwards misses.
- R7: With `req_valid` low, `syn_hit` stays low and no entry is invalidated.
- R8: If several locations match, the lowest candidate c wins. Within one candidate, the lowest way wins.
- R9: If a fill and a hit-driven invalidate address the same entry at the same edge, the fill wins and the entry stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Primary cache is filling a line this cycle |
| fill_set | input | 9 | Set being filled |
| fill_way | input | 1 | Way being filled |
| fill_tag | input | 28 | Physical tag of the filled line |
| req_valid | input | 1 | Miss lookup request |
| req_pblk | input | 34 | Physical block address of the miss |
| req_vhi | input | 3 | Virtual upper set-index bits used by the requester |
| syn_hit | output | 1 | Synonym found (also the invalidate strobe for the primary tags) |
| syn_set | output | 9 | Set that holds the synonym |
| syn_way | output | 1 | Way that holds the synonym |

## Verification
The lookups use blocks placed at a foreign candidate set, which must hit. They also use the same block at the requester's own set, which separates exclusion from a plain miss. Other patterns have a matching tag but different low index bits, or a tag that differs by one bit, which separates a tag compare from an index compare. Repeating a lookup right after a hit shows whether the invalidate took effect. Two deliberately duplicated copies check the priority order, and a fill that coincides with an invalidate checks which one wins.

// File: rtl/syn_pkg.sv
package syn_pkg;
  localparam int PA_W_D   = 40;
  localparam int OFS_W_D  = 6;
  localparam int IDX_W_D  = 9;
  localparam int PAGE_W_D = 12;
  localparam int WAYS_D   = 2;
endpackage

// File: rtl/syn_tag_store.sv
module syn_tag_store #(
  parameter int IDX_W   = 9,
  parameter int ALIAS_W = 3,
  parameter int TAG_W   = 28,
  parameter int WAYS    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_set,
  input  logic [$clog2(WAYS)-1:0]      wr_way,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic                         clr_en,
  input  logic [IDX_W-1:0]             clr_set,
  input  logic [$clog2(WAYS)-1:0]      clr_way,
  input  logic [IDX_W-ALIAS_W-1:0]     rd_low,
  output logic [TAG_W-1:0]             rd_tag [(1<<ALIAS_W)*WAYS],
  output logic [(1<<ALIAS_W)*WAYS-1:0] rd_vld
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int ENT_W = IDX_W + WAY_W;
  localparam int ENTS  = 1 << ENT_W;
  localparam int CAND  = 1 << ALIAS_W;

  logic [ENTS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [ENTS];
  logic [ENT_W-1:0] wr_ent, clr_ent;
  logic             wr_clr_same;

  assign wr_ent      = {wr_set, wr_way};
  assign clr_ent     = {clr_set, clr_way};
  assign wr_clr_same = wr_en && clr_en && (wr_ent == clr_ent);

  // Later assignment wins: a fill overrides a same-edge clear (R9)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (clr_en) vld_q[clr_ent] <= 1'b0;
      if (wr_en)  vld_q[wr_ent]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_ent] <= wr_tag;
  end

  for (genvar c = 0; c < CAND; c++) begin : g_cand
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      localparam logic [ALIAS_W-1:0] CV = ALIAS_W'(c);
      localparam logic [WAY_W-1:0]   WV = WAY_W'(w);
      assign rd_tag[c*WAYS+w] = tag_q[{CV, rd_low, WV}];
      assign rd_vld[c*WAYS+w] = vld_q[{CV, rd_low, WV}];
    end
  end

  a_r2_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_ent)]);
  a_r6_clear_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_clr_same) |=> !vld_q[$past(clr_ent)]);
  a_r9_fill_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_same |=> vld_q[$past(clr_ent)]);
endmodule

// File: rtl/syn_pick.sv
module syn_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0]         vec,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IDW = $clog2(N);

  function automatic logic [IDW-1:0] lowest_set(input logic [N-1:0] v);
    logic [IDW-1:0] r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = IDW'(i);
    return r;
  endfunction

  assign found = |vec;
  assign idx   = lowest_set(vec);

  // R8: the chosen bit is set and no lower bit is set
  always_comb begin
    if (found) begin
      a_r8_pick_is_set: assert (vec[idx]);
      a_r8_pick_lowest: assert ((vec & ((N'(1) << idx) - N'(1))) == '0);
    end
  end
endmodule

// File: rtl/syn_detect.sv
module syn_detect #(
  parameter int PA_W   = syn_pkg::PA_W_D,
  parameter int OFS_W  = syn_pkg::OFS_W_D,
  parameter int IDX_W  = syn_pkg::IDX_W_D,
  parameter int PAGE_W = syn_pkg::PAGE_W_D,
  parameter int WAYS   = syn_pkg::WAYS_D
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 fill_en,
  input  logic [IDX_W-1:0]                     fill_set,
  input  logic [$clog2(WAYS)-1:0]              fill_way,
  input  logic [PA_W-PAGE_W-1:0]               fill_tag,
  input  logic                                 req_valid,
  input  logic [PA_W-OFS_W-1:0]                req_pblk,
  input  logic [IDX_W+OFS_W-PAGE_W-1:0]        req_vhi,
  output logic                                 syn_hit,
  output logic [IDX_W-1:0]                     syn_set,
  output logic [$clog2(WAYS)-1:0]              syn_way
);
  localparam int ALIAS_W = IDX_W + OFS_W - PAGE_W;
  localparam int CAND    = 1 << ALIAS_W;
  localparam int LOW_W   = IDX_W - ALIAS_W;
  localparam int TAG_W   = PA_W - PAGE_W;
  localparam int BLK_W   = PA_W - OFS_W;
  localparam int WAY_W   = $clog2(WAYS);
  localparam int LOCS    = CAND * WAYS;
  localparam int IDW     = $clog2(LOCS);

  function automatic logic [TAG_W-1:0] blk_tag(input logic [BLK_W-1:0] b);
    return b[BLK_W-1:LOW_W];
  endfunction

  function automatic logic [LOW_W-1:0] blk_low(input logic [BLK_W-1:0] b);
    return b[LOW_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] cand_set(input logic [ALIAS_W-1:0] c,
                                                input logic [LOW_W-1:0] low);
    return {c, low};
  endfunction

  logic [TAG_W-1:0] cand_tag [LOCS];
  logic [LOCS-1:0]  cand_vld;
  logic [LOCS-1:0]  match_vec;
  logic             any_match;
  logic [IDW-1:0]   match_idx;
  logic [TAG_W-1:0] req_tag;
  logic [LOW_W-1:0] req_low;

  assign req_tag = blk_tag(req_pblk);
  assign req_low = blk_low(req_pblk);

  syn_tag_store #(.IDX_W(IDX_W), .ALIAS_W(ALIAS_W), .TAG_W(TAG_W), .WAYS(WAYS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fill_en),
    .wr_set  (fill_set),
    .wr_way  (fill_way),
    .wr_tag  (fill_tag),
    .clr_en  (syn_hit),
    .clr_set (syn_set),
    .clr_way (syn_way),
    .rd_low  (req_low),
    .rd_tag  (cand_tag),
    .rd_vld  (cand_vld)
  );

  for (genvar c = 0; c < CAND; c++) begin : g_cmp
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign match_vec[c*WAYS+w] = req_valid && cand_vld[c*WAYS+w]
                                 && (cand_tag[c*WAYS+w] == req_tag)
                                 && (ALIAS_W'(c) != req_vhi);
    end
  end

  syn_pick #(.N(LOCS)) u_pick (
    .vec   (match_vec),
    .found (any_match),
    .idx   (match_idx)
  );

  assign syn_hit = any_match;
  assign syn_set = cand_set(match_idx[IDW-1:WAY_W], req_low);
  assign syn_way = match_idx[WAY_W-1:0];

  a_r7_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !syn_hit);
  a_r4_not_own_set: assert property (@(posedge clk) disable iff (!rst_n)
    syn_hit |-> (syn_set[IDX_W-1:LOW_W] != req_vhi));
  a_r3_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    syn_hit |-> (syn_set[LOW_W-1:0] == req_low));
  a_r6_hit_gone_next: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_hit && !fill_en && req_valid) |=> !(req_valid && syn_hit
      && syn_set == $past(syn_set) && syn_way == $past(syn_way)
      && req_pblk == $past(req_pblk)));
endmodule

// File: tb/syn_detect_bench.sv
module syn_detect_bench;
  localparam int P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fill_en = 1'b0;
  logic [8:0]  fill_set = '0;
  logic [0:0]  fill_way = '0;
  logic [27:0] fill_tag = '0;
  logic        req_valid = 1'b0;
  logic [33:0] req_pblk = '0;
  logic [2:0]  req_vhi = '0;
  logic        syn_hit;
  logic [8:0]  syn_set;
  logic [0:0]  syn_way;

  int checks = 0;
  int errors = 0;

  always #(P/2) clk = ~clk;

  syn_detect u_syn_detect (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_set(fill_set),
    .fill_way(fill_way), .fill_tag(fill_tag), .req_valid(req_valid),
    .req_pblk(req_pblk), .req_vhi(req_vhi), .syn_hit(syn_hit),
    .syn_set(syn_set), .syn_way(syn_way)
  );

  localparam logic [27:0] TA = 28'h0ABCDE1;
  localparam logic [27:0] TB = 28'h1234567;
  localparam logic [27:0] TC = 28'hFFFFFFF;
  localparam logic [27:0] TD = 28'h0D0D0D0;
  localparam logic [27:0] TE = 28'h0E0E0E0;
  localparam logic [27:0] TF = 28'h0F0F0F0;

  typedef struct packed {
    logic [33:0] pblk;
    logic [2:0]  vhi;
    logic        hit;
    logic [8:0]  set;
    logic        way;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{pblk: {TA, 6'h12},         vhi: 3'd5, hit: 1'b0, set: 9'h000, way: 1'b0}, // R4 own set
    '{pblk: {TA, 6'h12},         vhi: 3'd3, hit: 1'b1, set: 9'h152, way: 1'b1}, // R3 foreign set
    '{pblk: {TA, 6'h12},         vhi: 3'd3, hit: 1'b0, set: 9'h000, way: 1'b0}, // R6 invalidated
    '{pblk: {TB, 6'h3F},         vhi: 3'd0, hit: 1'b0, set: 9'h000, way: 1'b0}, // R4 own set
    '{pblk: {TB, 6'h3F},         vhi: 3'd7, hit: 1'b1, set: 9'h03F, way: 1'b0}, // R3 candidate 0
    '{pblk: {TA, 6'h12},         vhi: 3'd2, hit: 1'b0, set: 9'h000, way: 1'b0}, // R5 low bits differ
    '{pblk: {TA, 6'h07},         vhi: 3'd6, hit: 1'b1, set: 9'h087, way: 1'b0}, // R2 fill found
    '{pblk: {TC ^ 28'h1, 6'h00}, vhi: 3'd0, hit: 1'b0, set: 9'h000, way: 1'b0}, // R5 tag differs
    '{pblk: {TC, 6'h00},         vhi: 3'd0, hit: 1'b1, set: 9'h1C0, way: 1'b1}  // R3 top candidate
  };

  task automatic fill(input logic [8:0] s, input logic w, input logic [27:0] t);
    @(negedge clk);
    fill_en = 1'b1; fill_set = s; fill_way = w; fill_tag = t;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic check(input string req, input logic eh, input logic [8:0] es,
                       input logic ew);
    checks++;
    if (syn_hit !== eh || (eh && (syn_set !== es || syn_way !== ew))) begin
      errors++;
      $display("FAIL %s: hit/set/way actual %b/%h/%b expected %b/%h/%b",
               req, syn_hit, syn_set, syn_way, eh, es, ew);
    end
  endtask

  task automatic lookup(input string req, input logic [33:0] pb, input logic [2:0] vh,
                        input logic eh, input logic [8:0] es, input logic ew);
    @(negedge clk);
    req_valid = 1'b1; req_pblk = pb; req_vhi = vh;
    #(P/4);
    check(req, eh, es, ew);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(P*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing valid right after reset
    lookup("R1 empty after reset", {TA, 6'h12}, 3'd0, 1'b0, 9'h0, 1'b0);

    fill({3'd5, 6'h12}, 1'b1, TA);
    fill({3'd0, 6'h3F}, 1'b0, TB);
    fill({3'd2, 6'h07}, 1'b0, TA);
    fill({3'd7, 6'h00}, 1'b1, TC);

    // R7: request not valid, no hit and entry must survive (row 1 hits it)
    @(negedge clk);
    req_valid = 1'b0; req_pblk = {TA, 6'h12}; req_vhi = 3'd3;
    #(P/4);
    check("R7 idle request", 1'b0, 9'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      lookup($sformatf("table row %0d (R2 R3 R4 R5 R6)", i), VECS[i].pblk, VECS[i].vhi,
             VECS[i].hit, VECS[i].set, VECS[i].way);
    end

    // R8: two copies, lowest candidate then way wins
    fill({3'd4, 6'h20}, 1'b0, TE);
    fill({3'd1, 6'h20}, 1'b1, TE);
    lookup("R8 lowest candidate", {TE, 6'h20}, 3'd0, 1'b1, 9'h060, 1'b1);
    lookup("R8 next copy", {TE, 6'h20}, 3'd0, 1'b1, 9'h120, 1'b0);
    lookup("R8 both cleared", {TE, 6'h20}, 3'd0, 1'b0, 9'h0, 1'b0);

    // R9: fill and invalidate on the same entry, fill wins
    fill({3'd3, 6'h2A}, 1'b0, TD);
    @(negedge clk);
    req_valid = 1'b1; req_pblk = {TD, 6'h2A}; req_vhi = 3'd0;
    fill_en = 1'b1; fill_set = {3'd3, 6'h2A}; fill_way = 1'b0; fill_tag = TD;
    #(P/4);
    check("R9 hit during fill", 1'b1, 9'h0EA, 1'b0);
    @(negedge clk);
    req_valid = 1'b0; fill_en = 1'b0;
    lookup("R9 entry kept", {TD, 6'h2A}, 3'd0, 1'b1, 9'h0EA, 1'b0);

    // R1: reset clears a valid entry
    fill({3'd6, 6'h11}, 1'b1, TF);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lookup("R1 cleared by reset", {TF, 6'h11}, 3'd0, 1'b0, 9'h0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule